// File: doc/BRIEF.md
# Optical Sensor Boot Sequencer

This block brings an optical motion sensor out of power-on into a working, checked state. On a start pulse it walks a fixed list of serial register transactions. It powers the sensor off and then soft-resets it. It flushes the motion and delta registers, arms the sensor's program memory and streams a firmware image into it in one paced burst. It then programs resolution, a second configuration register and a rotation trim. Last, it reads three identity registers and compares them with known values. When the list ends it raises `done`, and `success` reports whether all three identity reads matched.

The serial side is a four-wire link with the clock idling high, data launched on the falling edge, sampled on the rising edge, most significant bit first. A write frame is the address with bit 7 set followed by the data byte. A read frame is the address with bit 7 clear followed by a dummy 0x00 while the sensor returns its byte. Every delay is counted in microsecond ticks of `TICK_CYC` clock cycles, and a millisecond is `US_PER_MS` ticks, so both can be compressed for test.

The firmware image enters on a valid/ready byte stream of exactly `FW_LEN` bytes. `fw_ready` is high only while the sequencer waits for the next image byte inside the burst. A byte is taken on a clock edge where `fw_valid` and `fw_ready` are both high. The source may hold `fw_valid` low for any time; the burst frame then stays open and simply waits. `fw_data` must be stable while `fw_valid` is high.

Top module: `optsens_boot_seq`

## Requirements
- R1: After reset, `spi_cs_n`=1, `spi_sclk`=1, `done`=0, `success`=0, `fw_ready`=0.
- R2: The first frames are, in order: write 0xB6 to address 0x3B; a select-only pulse with no clock edges; write 0x5A to address 0x3A; reads of 0x02, 0x03, 0x04, 0x05, 0x06 whose results are dropped. A write frame is {addr|0x80, data}; a read frame is {addr&0x7F, 0x00}.
- R3: Select stays released for at least 300 ms after the power-off write, 40 us after the pulse, 50 ms after the soft reset, 10 ms after the first program-memory write, 10 ms after the post-burst configuration write, 1 ms after the resolution write, and 1 us between all other frames.
- R4: Program memory is armed by writing 0x1D and then 0x18 to address 0x13.
- R5: The burst is one frame: 0xE2 (0x62 with bit 7 set) followed by the `FW_LEN` image bytes in stream order. Each byte starts no sooner than 15 us after the previous byte ends, and select stays asserted for 200 us after the last byte.
- R6: `fw_ready` is high only inside the open burst frame. While the stream is empty, select stays asserted and no clock edges occur.
- R7: After the burst, address 0x2A is read and its value dropped, then 0x00 is written to address 0x10.
- R8: The resolution write to address 0x0F carries cpi/100 − 1 (integer division), clamped to 0..119.
- R9: After the resolution write, 0x00 is written to 0x10. Then the rotation trim, clamped to −30..+30 and sent as an 8-bit two's complement value, is written to address 0x11.
- R10: The last frames read 0x00, 0x3F and 0x2A. `success` is 1 only if they returned 0x42, 0xBD and 0x04 respectively.
- R11: `done` rises after the last frame, holding select released, and holds until the next `start`. `start` clears `done` and `success` and restarts from the power-off write, even in the middle of a sequence.
- R12: With select released, `spi_sclk` is high, and `spi_mosi` never changes while `spi_sclk` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse: begin or restart the sequence |
| cpi_req | input | CPI_W | Requested resolution in counts per inch |
| angle_req | input | 8 | Requested rotation trim, signed degrees |
| fw_data | input | 8 | Firmware image byte |
| fw_valid | input | 1 | Image byte present |
| fw_ready | output | 1 | Sequencer takes an image byte this cycle |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data to sensor |
| spi_miso | input | 1 | Serial data from sensor |
| spi_cs_n | output | 1 | Sensor select, active low |
| done | output | 1 | Sequence finished |
| success | output | 1 | Identity check passed (valid with done) |

## Verification
The bench models the sensor on the serial pins. It compares every frame, byte for byte, with a scoreboard built from the requirements, and measures the released-select time before each frame. It stalls the image stream mid-burst. A design that closed the frame or kept clocking during the stall would split the burst or corrupt a byte. It restarts the sequence during the long power-off wait; a design that resumed instead of restarting would skip the power-off write. Resolution values below 100 and above 12000, and trims of ±100, probe the clamps, where a wrap would send 0xFF or a large byte. One run returns a wrong inverse identity to show that `success` falls, and the next run shows that it comes back.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [2:0] {
    OP_WR    = 3'd0,
    OP_RD    = 3'd1,
    OP_PULSE = 3'd2,
    OP_BURST = 3'd3,
    OP_END   = 3'd4
  } op_e;

  typedef struct packed {
    op_e        op;
    logic [7:0] addr;
    logic [7:0] data;
    logic       chk;
    logic [7:0] want;
  } step_t;

  // sensor register addresses
  localparam logic [7:0] A_POWER_OFF = 8'h3B;
  localparam logic [7:0] A_SOFT_RST  = 8'h3A;
  localparam logic [7:0] A_MOT       = 8'h02;
  localparam logic [7:0] A_DX_LO     = 8'h03;
  localparam logic [7:0] A_DX_HI     = 8'h04;
  localparam logic [7:0] A_DY_LO     = 8'h05;
  localparam logic [7:0] A_DY_HI     = 8'h06;
  localparam logic [7:0] A_PM_CTRL   = 8'h13;
  localparam logic [7:0] A_PM_STREAM = 8'h62;
  localparam logic [7:0] A_PM_VER    = 8'h2A;
  localparam logic [7:0] A_CFG_B     = 8'h10;
  localparam logic [7:0] A_RES       = 8'h0F;
  localparam logic [7:0] A_ROT       = 8'h11;
  localparam logic [7:0] A_IDENT     = 8'h00;
  localparam logic [7:0] A_IDENT_INV = 8'h3F;

  // magic values
  localparam logic [7:0] K_POWER_OFF = 8'hB6;
  localparam logic [7:0] K_SOFT_RST  = 8'h5A;
  localparam logic [7:0] K_PM_ARM    = 8'h1D;
  localparam logic [7:0] K_PM_GO     = 8'h18;
  localparam logic [7:0] K_IDENT     = 8'h42;
  localparam logic [7:0] K_IDENT_INV = 8'hBD;
  localparam logic [7:0] K_PM_VER    = 8'h04;

  // microsecond delays
  localparam int T_SETUP_US  = 1;
  localparam int T_WR_HOLD   = 120;
  localparam int T_RD_HOLD   = 20;
  localparam int T_PULSE_US  = 40;
  localparam int T_BYTE_GAP  = 15;
  localparam int T_BURST_END = 200;

  localparam int NUM_STEPS = 20;

endpackage

// File: rtl/boot_tick_timer.sv
module boot_tick_timer #(
  parameter int TICK_CYC = 125,
  parameter int DLY_W    = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DLY_W-1:0] load_us,
  output logic             expired
);
  localparam int PRE_W = $clog2(TICK_CYC + 1);
  localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(TICK_CYC - 1);

  logic [DLY_W-1:0] us_left;
  logic [PRE_W-1:0] pre;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      us_left <= '0;
      pre     <= PRE_TOP;
    end else if (load) begin
      us_left <= load_us;
      pre     <= PRE_TOP;
    end else if (us_left != '0) begin
      if (pre == '0) begin
        pre     <= PRE_TOP;
        us_left <= us_left - 1'b1;
      end else begin
        pre <= pre - 1'b1;
      end
    end
  end

  assign expired = (us_left == '0);
endmodule

// File: rtl/boot_spi_shifter.sv
module boot_spi_shifter #(
  parameter int HALF_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic [7:0] rx,
  output logic       done
);
  localparam int HC_W = $clog2(HALF_CYC + 1);
  localparam logic [HC_W-1:0] HC_TOP = HC_W'(HALF_CYC - 1);

  logic            active;
  logic            hi_phase;
  logic [2:0]      bit_cnt;
  logic [HC_W-1:0] half_cnt;
  logic [7:0]      sh_tx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      hi_phase <= 1'b0;
      bit_cnt  <= '0;
      half_cnt <= '0;
      sh_tx    <= '0;
      rx       <= '0;
      sclk     <= 1'b1;
      mosi     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      if (abort) begin
        active <= 1'b0;
        sclk   <= 1'b1;
      end else if (go && !active) begin
        active   <= 1'b1;
        sh_tx    <= tx;
        mosi     <= tx[7];
        sclk     <= 1'b0;
        hi_phase <= 1'b0;
        bit_cnt  <= '0;
        half_cnt <= HC_TOP;
      end else if (active) begin
        if (half_cnt != '0) begin
          half_cnt <= half_cnt - 1'b1;
        end else begin
          half_cnt <= HC_TOP;
          if (!hi_phase) begin
            sclk     <= 1'b1;
            hi_phase <= 1'b1;
            rx       <= {rx[6:0], miso};
          end else if (bit_cnt == 3'd7) begin
            active <= 1'b0;
            done   <= 1'b1;
          end else begin
            bit_cnt  <= bit_cnt + 1'b1;
            sh_tx    <= {sh_tx[6:0], 1'b0};
            mosi     <= sh_tx[6];
            sclk     <= 1'b0;
            hi_phase <= 1'b0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/boot_step_rom.sv
module boot_step_rom
  import boot_seq_pkg::*;
#(
  parameter int US_PER_MS = 1000,
  parameter int CPI_W     = 16,
  parameter int DLY_W     = 20,
  parameter int IDX_W     = 5
) (
  input  logic [IDX_W-1:0]  idx,
  input  logic [CPI_W-1:0]  cpi,
  input  logic signed [7:0] angle,
  output step_t             step,
  output logic [DLY_W-1:0]  gap_us
);
  logic [CPI_W-1:0]  cpi_q;
  logic [7:0]        res_byte;
  logic signed [7:0] rot_byte;
  int                gap_n;

  always_comb begin
    cpi_q = cpi / CPI_W'(100);
    if (cpi_q == '0)                res_byte = 8'd0;
    else if (cpi_q > CPI_W'(120))   res_byte = 8'd119;
    else                            res_byte = 8'(cpi_q - 1'b1);
    if (angle < -8'sd30)            rot_byte = -8'sd30;
    else if (angle > 8'sd30)        rot_byte = 8'sd30;
    else                            rot_byte = angle;
  end

  always_comb begin
    step  = '{op: OP_END, addr: 8'h00, data: 8'h00, chk: 1'b0, want: 8'h00};
    gap_n = 1;
    case (idx)
      5'd0:  begin step.op = OP_WR;    step.addr = A_POWER_OFF; step.data = K_POWER_OFF; gap_n = 300 * US_PER_MS; end
      5'd1:  begin step.op = OP_PULSE; gap_n = T_PULSE_US; end
      5'd2:  begin step.op = OP_WR;    step.addr = A_SOFT_RST;  step.data = K_SOFT_RST;  gap_n = 50 * US_PER_MS; end
      5'd3:  begin step.op = OP_RD;    step.addr = A_MOT;   end
      5'd4:  begin step.op = OP_RD;    step.addr = A_DX_LO; end
      5'd5:  begin step.op = OP_RD;    step.addr = A_DX_HI; end
      5'd6:  begin step.op = OP_RD;    step.addr = A_DY_LO; end
      5'd7:  begin step.op = OP_RD;    step.addr = A_DY_HI; end
      5'd8:  begin step.op = OP_WR;    step.addr = A_PM_CTRL; step.data = K_PM_ARM; gap_n = 10 * US_PER_MS; end
      5'd9:  begin step.op = OP_WR;    step.addr = A_PM_CTRL; step.data = K_PM_GO;  end
      5'd10: begin step.op = OP_BURST; step.addr = A_PM_STREAM; end
      5'd11: begin step.op = OP_RD;    step.addr = A_PM_VER; end
      5'd12: begin step.op = OP_WR;    step.addr = A_CFG_B; step.data = 8'h00; gap_n = 10 * US_PER_MS; end
      5'd13: begin step.op = OP_WR;    step.addr = A_RES;   step.data = res_byte; gap_n = US_PER_MS; end
      5'd14: begin step.op = OP_WR;    step.addr = A_CFG_B; step.data = 8'h00; end
      5'd15: begin step.op = OP_WR;    step.addr = A_ROT;   step.data = rot_byte; end
      5'd16: begin step.op = OP_RD;    step.addr = A_IDENT;     step.chk = 1'b1; step.want = K_IDENT; end
      5'd17: begin step.op = OP_RD;    step.addr = A_IDENT_INV; step.chk = 1'b1; step.want = K_IDENT_INV; end
      5'd18: begin step.op = OP_RD;    step.addr = A_PM_VER;    step.chk = 1'b1; step.want = K_PM_VER; end
      default: ;
    endcase
    gap_us = DLY_W'(gap_n);
  end
endmodule

// File: rtl/optsens_boot_seq.sv
module optsens_boot_seq
  import boot_seq_pkg::*;
#(
  parameter int TICK_CYC  = 125,
  parameter int US_PER_MS = 1000,
  parameter int SCLK_HALF = 2,
  parameter int FW_LEN    = 4094,
  parameter int CPI_W     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CPI_W-1:0]  cpi_req,
  input  logic signed [7:0] angle_req,
  input  logic [7:0]        fw_data,
  input  logic              fw_valid,
  output logic              fw_ready,
  output logic              spi_sclk,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n,
  output logic              done,
  output logic              success
);
  localparam int MAX_US = 300 * US_PER_MS;
  localparam int DLY_W  = $clog2(MAX_US + 512);
  localparam int FWC_W  = $clog2(FW_LEN + 1);
  localparam int IDX_W  = 5;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_SETUP, ST_SHIFT, ST_FW_GAP,
    ST_FW_WAIT, ST_HOLD, ST_PULSE, ST_GAP
  } st_e;

  st_e              state, nxt;
  logic [IDX_W-1:0] idx;
  logic             byte_sel;
  logic [FWC_W-1:0] fw_cnt;
  logic             chk_bad;
  logic             cs_q;

  step_t            step;
  logic [DLY_W-1:0] gap_us;
  logic             tmr_load, tmr_exp;
  logic [DLY_W-1:0] tmr_us;
  logic             sh_go, sh_done;
  logic [7:0]       sh_byte, sh_rx;

  boot_step_rom #(.US_PER_MS(US_PER_MS), .CPI_W(CPI_W), .DLY_W(DLY_W), .IDX_W(IDX_W)) rom_i (
    .idx(idx), .cpi(cpi_req), .angle(angle_req), .step(step), .gap_us(gap_us));

  boot_tick_timer #(.TICK_CYC(TICK_CYC), .DLY_W(DLY_W)) tmr_i (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_us(tmr_us), .expired(tmr_exp));

  boot_spi_shifter #(.HALF_CYC(SCLK_HALF)) shf_i (
    .clk(clk), .rst_n(rst_n), .abort(start), .go(sh_go), .tx(sh_byte),
    .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .rx(sh_rx), .done(sh_done));

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_us   = '0;
    sh_go    = 1'b0;
    sh_byte  = '0;
    case (state)
      ST_FETCH: begin
        if (step.op == OP_END) begin
          nxt = ST_IDLE;
        end else if (step.op == OP_PULSE) begin
          tmr_load = 1'b1; tmr_us = DLY_W'(T_PULSE_US); nxt = ST_PULSE;
        end else begin
          tmr_load = 1'b1; tmr_us = DLY_W'(T_SETUP_US); nxt = ST_SETUP;
        end
      end
      ST_SETUP: if (tmr_exp) begin
        sh_go   = 1'b1;
        sh_byte = {(step.op != OP_RD), step.addr[6:0]};
        nxt     = ST_SHIFT;
      end
      ST_SHIFT: if (sh_done) begin
        if (step.op == OP_BURST) begin
          tmr_load = 1'b1; tmr_us = DLY_W'(T_BYTE_GAP); nxt = ST_FW_GAP;
        end else if (!byte_sel) begin
          sh_go   = 1'b1;
          sh_byte = (step.op == OP_WR) ? step.data : 8'h00;
        end else begin
          tmr_load = 1'b1;
          tmr_us   = (step.op == OP_WR) ? DLY_W'(T_WR_HOLD) : DLY_W'(T_RD_HOLD);
          nxt      = ST_HOLD;
        end
      end
      ST_FW_GAP: if (tmr_exp) begin
        if (fw_cnt == FWC_W'(FW_LEN)) begin
          tmr_load = 1'b1; tmr_us = DLY_W'(T_BURST_END); nxt = ST_HOLD;
        end else begin
          nxt = ST_FW_WAIT;
        end
      end
      ST_FW_WAIT: if (fw_valid) begin
        sh_go = 1'b1; sh_byte = fw_data; nxt = ST_SHIFT;
      end
      ST_HOLD, ST_PULSE: if (tmr_exp) begin
        tmr_load = 1'b1; tmr_us = gap_us; nxt = ST_GAP;
      end
      ST_GAP: if (tmr_exp) nxt = ST_FETCH;
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      idx      <= '0;
      byte_sel <= 1'b0;
      fw_cnt   <= '0;
      chk_bad  <= 1'b0;
      cs_q     <= 1'b1;
      done     <= 1'b0;
      success  <= 1'b0;
    end else if (start) begin
      state    <= ST_FETCH;
      idx      <= '0;
      byte_sel <= 1'b0;
      fw_cnt   <= '0;
      chk_bad  <= 1'b0;
      cs_q     <= 1'b1;
      done     <= 1'b0;
      success  <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_FETCH) begin
        byte_sel <= 1'b0;
        fw_cnt   <= '0;
        if (step.op == OP_END) begin
          done    <= 1'b1;
          success <= !chk_bad;
        end else begin
          cs_q <= 1'b0;
        end
      end
      if (state == ST_SHIFT && sh_done) begin
        byte_sel <= 1'b1;
        if (byte_sel && step.op == OP_RD && step.chk && sh_rx != step.want)
          chk_bad <= 1'b1;
      end
      if (state == ST_FW_WAIT && fw_valid) fw_cnt <= fw_cnt + 1'b1;
      if ((state == ST_HOLD || state == ST_PULSE) && tmr_exp) cs_q <= 1'b1;
      if (state == ST_GAP && tmr_exp) idx <= idx + 1'b1;
    end
  end

  assign spi_cs_n = cs_q;
  assign fw_ready = (state == ST_FW_WAIT);
endmodule

// File: rtl/optsens_boot_seq_chk.sv
module optsens_boot_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic spi_cs_n,
  input logic spi_sclk,
  input logic spi_mosi,
  input logic fw_ready,
  input logic fw_valid,
  input logic done,
  input logic success
);
  a_r12_sclk_idle: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> spi_sclk);

  a_r12_mosi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  a_r6_ready_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
    fw_ready |-> !spi_cs_n);

  a_r6_ready_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (fw_ready && !fw_valid && !start) |=> fw_ready);

  a_r11_done_released: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (spi_cs_n && !fw_ready));

  a_r11_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  a_r11_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && !success));

  a_r10_success_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    success |-> done);
endmodule

bind optsens_boot_seq optsens_boot_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .spi_cs_n(spi_cs_n),
  .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .fw_ready(fw_ready),
  .fw_valid(fw_valid), .done(done), .success(success));

// File: tb/optsens_boot_seq_tb_top.sv
module optsens_boot_seq_tb_top;
  localparam int TB_TICK = 2;
  localparam int TB_MS   = 4;
  localparam int TB_HALF = 1;
  localparam int TB_FW   = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] cpi_req = 16'd1600;
  logic signed [7:0] angle_req = 8'sd0;
  logic [7:0] fw_data = 8'h00;
  logic fw_valid = 1'b0;
  logic fw_ready, spi_sclk, spi_mosi, spi_cs_n, done, success;
  logic spi_miso = 1'b0;

  always #4 clk = ~clk;

  optsens_boot_seq #(.TICK_CYC(TB_TICK), .US_PER_MS(TB_MS), .SCLK_HALF(TB_HALF),
                     .FW_LEN(TB_FW), .CPI_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cpi_req(cpi_req), .angle_req(angle_req),
    .fw_data(fw_data), .fw_valid(fw_valid), .fw_ready(fw_ready),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n),
    .done(done), .success(success));

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit armed = 0;
  bit finished = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // scoreboard queues
  logic [7:0] exp_b[$];
  int         exp_len[$];
  int         exp_gap[$];
  string      exp_tag[$];

  // sensor identity values returned on reads
  logic [7:0] id_v = 8'h42, inv_v = 8'hBD, ver_v = 8'h04;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] want);
    checks++;
    if (act !== want) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, want);
    end
  endtask

  function automatic logic [7:0] fw_byte(input logic [7:0] seed, input int i);
    return seed + 8'(i * 37);
  endfunction

  function automatic logic [7:0] res_val(input int cpi);
    int v = cpi / 100 - 1;
    if (v < 0) v = 0;
    if (v > 119) v = 119;
    return 8'(v);
  endfunction

  function automatic logic [7:0] rot_val(input int a);
    if (a < -30) a = -30;
    if (a > 30) a = 30;
    return 8'(a);
  endfunction

  task automatic push_hdr(input string tag, input int gap, input int len);
    exp_tag.push_back(tag); exp_gap.push_back(gap); exp_len.push_back(len);
  endtask
  task automatic push_wr(input string tag, input int gap, input logic [7:0] a, input logic [7:0] d);
    push_hdr(tag, gap, 2); exp_b.push_back(a | 8'h80); exp_b.push_back(d);
  endtask
  task automatic push_rd(input string tag, input int gap, input logic [7:0] a);
    push_hdr(tag, gap, 2); exp_b.push_back(a & 8'h7F); exp_b.push_back(8'h00);
  endtask

  // driver side of the scoreboard: whole expected frame list of one run
  task automatic push_run(input int cpi, input int ang, input logic [7:0] seed);
    push_wr("R2", 0, 8'h3B, 8'hB6);
    push_hdr("R2", 300 * TB_MS, 0);               // select-only pulse
    push_wr("R2", 40, 8'h3A, 8'h5A);
    push_rd("R2", 50 * TB_MS, 8'h02);
    push_rd("R2", 1, 8'h03);
    push_rd("R2", 1, 8'h04);
    push_rd("R2", 1, 8'h05);
    push_rd("R2", 1, 8'h06);
    push_wr("R4", 1, 8'h13, 8'h1D);
    push_wr("R4", 10 * TB_MS, 8'h13, 8'h18);
    push_hdr("R5", 1, TB_FW + 1);
    exp_b.push_back(8'hE2);
    for (int i = 0; i < TB_FW; i++) exp_b.push_back(fw_byte(seed, i));
    push_rd("R7", 1, 8'h2A);
    push_wr("R7", 1, 8'h10, 8'h00);
    push_wr("R8", 10 * TB_MS, 8'h0F, res_val(cpi));
    push_wr("R9", TB_MS, 8'h10, 8'h00);
    push_wr("R9", 1, 8'h11, rot_val(ang));
    push_rd("R10", 1, 8'h00);
    push_rd("R10", 1, 8'h3F);
    push_rd("R10", 1, 8'h2A);
  endtask

  // sensor model and monitor
  logic [7:0] rxb[0:31];
  int         nbytes = 0;
  int         bcnt = 0;
  logic [7:0] sh = 8'h00;
  logic [7:0] resp = 8'h00;
  int         end_cyc[0:31];
  int         last_rise = 0;

  function automatic logic [7:0] reg_val(input logic [7:0] a);
    case (a)
      8'h00:   return id_v;
      8'h3F:   return inv_v;
      8'h2A:   return ver_v;
      default: return 8'h5C;
    endcase
  endfunction

  always @(posedge spi_sclk) if (armed && !spi_cs_n) begin
    sh = {sh[6:0], spi_mosi};
    bcnt++;
    if (bcnt == 8) begin
      bcnt = 0;
      if (nbytes < 32) begin
        rxb[nbytes] = sh;
        end_cyc[nbytes] = cyc;
      end
      nbytes++;
      if (nbytes == 1) resp = reg_val(sh);
      // R5: pacing inside the burst frame
      if (nbytes >= 2 && nbytes <= 32 && rxb[0] == 8'hE2)
        chk("R5 byte spacing", 32'(end_cyc[nbytes-1] - end_cyc[nbytes-2] >= 15 * TB_TICK + 16), 1);
    end
  end

  always @(negedge spi_sclk) if (armed && !spi_cs_n) begin
    spi_miso = resp[7];
    resp = {resp[6:0], 1'b0};
  end

  always @(negedge spi_cs_n) if (armed) begin
    nbytes = 0; bcnt = 0; resp = 8'h00;
    if (exp_gap.size() > 0)   // R3: released-select time before this frame
      chk("R3 select gap", 32'(cyc - last_rise >= exp_gap[0] * TB_TICK), 1);
  end

  always @(posedge spi_cs_n) if (armed) begin
    last_rise = cyc;
    if (exp_len.size() == 0) begin
      chk("R2 unexpected frame", 32'(nbytes), 32'hFFFF);
    end else begin
      automatic int    len = exp_len.pop_front();
      automatic string tag = exp_tag.pop_front();
      void'(exp_gap.pop_front());
      chk({tag, " frame length"}, 32'(nbytes), 32'(len));
      for (int i = 0; i < len; i++) begin
        automatic logic [7:0] w = exp_b.pop_front();
        if (i < nbytes && i < 32) chk({tag, " frame byte"}, 32'(rxb[i]), 32'(w));
      end
    end
  end

  // image source
  task automatic drive_fw(input logic [7:0] seed, input int stall_at);
    for (int i = 0; i < TB_FW; i++) begin
      @(negedge clk);
      while (!fw_ready) @(negedge clk);
      if (i == stall_at) begin
        repeat (100) @(negedge clk);
        chk("R6 select held while stream empty", 32'(spi_cs_n), 0);
        chk("R6 ready waits", 32'(fw_ready), 1);
        chk("R6 no clocking while stream empty", 32'(spi_sclk), 1);
      end
      fw_data  = fw_byte(seed, i);
      fw_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      fw_valid = 1'b0;
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    armed = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 cs_n", 32'(spi_cs_n), 1);
    chk("R1 sclk", 32'(spi_sclk), 1);
    chk("R1 done", 32'(done), 0);
    chk("R1 success", 32'(success), 0);
    chk("R1 fw_ready", 32'(fw_ready), 0);

    // run 1: nominal, stream stall mid-burst
    cpi_req = 16'd1600; angle_req = 8'sd0;
    push_run(1600, 0, 8'h10);
    fork drive_fw(8'h10, 4); join_none
    pulse_start();
    wait_done();
    chk("R10 success good ids", 32'(success), 1);
    chk("R11 done", 32'(done), 1);
    chk("R11 select released at done", 32'(spi_cs_n), 1);
    chk("R2 all frames seen", 32'(exp_len.size()), 0);
    repeat (20) @(negedge clk);
    chk("R11 done holds", 32'(done), 1);

    // run 2: restart during power-off wait, low clamps, bad inverse id
    inv_v = 8'hBC;
    cpi_req = 16'd50; angle_req = -8'sd100;
    push_run(50, -100, 8'h33);
    fork drive_fw(8'h33, -1); join_none
    pulse_start();
    chk("R11 start clears done", 32'(done), 0);
    @(posedge spi_cs_n);
    repeat (30) @(negedge clk);
    exp_b.delete(); exp_len.delete(); exp_gap.delete(); exp_tag.delete();
    push_run(50, -100, 8'h33);
    pulse_start();
    wait_done();
    chk("R10 success bad inverse id", 32'(success), 0);
    chk("R11 restart full sequence seen", 32'(exp_len.size()), 0);

    // run 3: high clamps, success recovers
    inv_v = 8'hBD;
    cpi_req = 16'd12100; angle_req = 8'sd100;
    push_run(12100, 100, 8'h77);
    fork drive_fw(8'h77, -1); join_none
    pulse_start();
    chk("R11 start clears success", 32'(success), 0);
    wait_done();
    chk("R10 success recovers", 32'(success), 1);
    chk("R8 R9 frames seen", 32'(exp_len.size()), 0);
    chk("R6 ready low at end", 32'(fw_ready), 0);

    finished = 1;
    summary();
  end
endmodule